// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Channel

This block produces one complementary pair of gate signals from a symmetric, center-aligned PWM. A signed up-counter runs from minus a modulo value to plus that value, so the middle of each period falls at count zero. A signed rise compare and a signed fall compare define the window in which the internal source signal is high. That source can be inverted, and it is then split into a high-side and a low-side output with a programmable dead gap between them.

Software loads shadow registers through a small write port and sets a load flag to request an update. The shadow values move into the active set only on the period reload pulse. Duty and period therefore change on a period boundary and never in the middle of a period. A channel can run as a master, where it raises its own reload when the count reaches the modulo. It can also run as a slave, where it restarts from an external sync input. Several channels, such as the two halves of a bridge, can then share one time base and use opposite source inversion for bipolar switching.

Top module: `cpwm_channel`

## Requirements
- R1: After a reload the count restarts at minus the active modulo (MOD) and rises by one per enabled cycle. In master mode `reload_o` is high in the cycle where the count equals MOD, which gives a period of 2*MOD+1 cycles.
- R2: The internal source is high in exactly those cycles where RISE <= count < FALL, both compared as signed values. With dead time D and window length W = FALL-RISE > D, `pwm_hi` is high for W-D cycles per period.
- R3: When FALL <= RISE, the source stays low for the whole period. `pwm_hi` never goes high and `pwm_lo` stays high continuously.
- R4: The shadow registers are written at wr_addr 0 (MOD, bits CW-2:0), 1 (RISE), 2 (FALL) and 3 (DEAD, bits DTW-1:0). They move to the active set only on a reload while the load flag is set. Writing any data to wr_addr 4 sets the flag, and a transfer clears it. Without the flag, shadow writes have no effect on the outputs.
- R5: A shadow write in the same cycle as a transfer is not part of that transfer. It waits in the shadow for the next one.
- R6: `pwm_hi` and `pwm_lo` are never high together. After one of them falls, the other stays low for DEAD cycles. With DEAD = 0 the pair is an exact complement and the low-side count per period is (2*MOD+1) - W - DEAD.
- R7: A source pulse lasting DEAD cycles or fewer produces no pulse on the matching output.
- R8: With `src_inv` = 1 the source is inverted before the dead-time stage, which swaps the high-side and low-side duty.
- R9: With `is_slave` = 1 the channel restarts its count, and pulses `reload_o`, in every enabled cycle where `ext_sync_i` is high. A slave fed by a master's `reload_o` stays aligned with it cycle for cycle.
- R10: Reset drives both outputs and `reload_o` low. The outputs stay low until the first reload after `enable`, and drop low again when `enable` is removed. Out of reset the count and MOD are both zero, so the first enabled cycle is a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the counter; low forces the outputs low |
| is_slave | input | 1 | 1: restart from ext_sync_i; 0: own modulo match |
| ext_sync_i | input | 1 | External reload/sync, used in slave mode |
| src_inv | input | 1 | Inverts the source before the dead-time stage |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 3 | Register select (0 MOD, 1 RISE, 2 FALL, 3 DEAD, 4 load flag) |
| wr_data | input | CW | Write data, signed for RISE and FALL |
| pwm_hi | output | 1 | High-side gate output |
| pwm_lo | output | 1 | Low-side gate output |
| reload_o | output | 1 | Reload pulse, once per period |

## Verification
Two functions can fall in the same cycle: a software write to a shadow register and the reload that transfers the shadow set. The bench waits until it sees `reload_o` high with the load flag already armed, and drives a RISE write into that very cycle. It then measures the high-side duty of the next full period, which must reflect the old RISE and the newly transferred FALL. After a further load request it measures again, and the duty must now include the late RISE. A lost or early-captured write shows up as a wrong count of high cycles.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Register select codes on the write port
  typedef enum logic [2:0] {
    SEL_MOD  = 3'd0,
    SEL_RISE = 3'd1,
    SEL_FALL = 3'd2,
    SEL_DEAD = 3'd3,
    SEL_LDOK = 3'd4
  } cpwm_sel_e;

  // Operating role of the time base
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } cpwm_role_e;

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [CW-1:0]        wr_data,
  input  logic                 rld,
  output logic [CW-2:0]        act_mod,
  output logic [CW-2:0]        mod_next,
  output logic signed [CW-1:0] act_rise,
  output logic signed [CW-1:0] act_fall,
  output logic [DTW-1:0]       act_dead,
  output logic                 xfer
);

  localparam int MW = CW - 1;

  logic [MW-1:0]        sh_mod;
  logic signed [CW-1:0] sh_rise;
  logic signed [CW-1:0] sh_fall;
  logic [DTW-1:0]       sh_dead;
  logic                 ldok_q;
  logic                 ldok_wr;
  cpwm_sel_e            sel;

  assign sel      = cpwm_sel_e'(wr_addr);
  assign ldok_wr  = wr_en && (sel == SEL_LDOK);
  // transfer event: reload while an update is requested
  assign xfer     = rld && ldok_q;
  assign mod_next = xfer ? sh_mod : act_mod;

  // shadow side, written by software at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mod  <= '0;
      sh_rise <= '0;
      sh_fall <= '0;
      sh_dead <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_MOD:  sh_mod  <= wr_data[MW-1:0];
        SEL_RISE: sh_rise <= wr_data;
        SEL_FALL: sh_fall <= wr_data;
        SEL_DEAD: sh_dead <= wr_data[DTW-1:0];
        default:  ;
      endcase
    end
  end

  // load request flag: a new request in the transfer cycle survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ldok_q <= 1'b0;
    else if (xfer)    ldok_q <= ldok_wr;
    else if (ldok_wr) ldok_q <= 1'b1;
  end

  // active side, loaded only on the transfer event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mod  <= '0;
      act_rise <= '0;
      act_fall <= '0;
      act_dead <= '0;
    end else if (xfer) begin
      act_mod  <= sh_mod;
      act_rise <= sh_rise;
      act_fall <= sh_fall;
      act_dead <= sh_dead;
    end
  end

  AST_LDOK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ldok_wr) |=> !ldok_q); // R4

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(act_mod) && $stable(act_rise) &&
               $stable(act_fall) && $stable(act_dead))); // R4

  AST_NO_XFER_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (rld && !ldok_q) |=> $stable(act_rise)); // R4

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 is_slave,
  input  logic                 ext_sync_i,
  input  logic [CW-2:0]        act_mod,
  input  logic [CW-2:0]        mod_next,
  output logic signed [CW-1:0] cnt,
  output logic                 rld,
  output logic                 started
);

  // modulo as a signed value, top bit always zero
  function automatic logic signed [CW-1:0] as_signed(input logic [CW-2:0] m);
    return signed'({1'b0, m});
  endfunction

  logic signed [CW-1:0] mod_s;
  logic                 at_top;
  cpwm_role_e           role;

  assign role   = cpwm_role_e'(is_slave);
  assign mod_s  = as_signed(act_mod);
  assign at_top = (cnt == mod_s);
  assign rld    = enable && ((role == ROLE_SLAVE) ? ext_sync_i : at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (rld)    cnt <= -as_signed(mod_next);
    else if (enable) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       started <= 1'b0;
    else if (!enable) started <= 1'b0;
    else if (rld)     started <= 1'b1;
  end

  AST_RESTART_AT_NEG_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    rld |=> (cnt == -mod_s)); // R1

  AST_MASTER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && role == ROLE_MASTER) |-> (cnt <= mod_s && cnt >= -mod_s)); // R1

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt)); // R10

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           src,
  input  logic [DTW-1:0] dead,
  output logic           pwm_hi,
  output logic           pwm_lo
);

  logic           prev_src;
  logic [DTW-1:0] dcnt;
  logic           edge_seen;
  logic           gap_done;

  assign edge_seen = (src != prev_src);
  // the last gap cycle: drive on the following edge
  assign gap_done  = (dcnt == {{(DTW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_src <= 1'b0;
      dcnt     <= '0;
      pwm_hi   <= 1'b0;
      pwm_lo   <= 1'b0;
    end else if (hold) begin
      prev_src <= src;
      dcnt     <= dead;
      pwm_hi   <= 1'b0;
      pwm_lo   <= 1'b0;
    end else if (edge_seen) begin
      // any source edge restarts the gap, so short pulses vanish
      prev_src <= src;
      dcnt     <= dead;
      pwm_hi   <= (dead == '0) && src;
      pwm_lo   <= (dead == '0) && !src;
    end else if (dcnt != '0) begin
      dcnt     <= dcnt - 1'b1;
      pwm_hi   <= gap_done && src;
      pwm_lo   <= gap_done && !src;
    end else begin
      pwm_hi   <= src;
      pwm_lo   <= !src;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_hi && pwm_lo)); // R6

  AST_HOLD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!pwm_hi && !pwm_lo)); // R10

  AST_GAP_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_hi) && $past(dead) != '0) |-> !pwm_lo); // R6

  AST_GAP_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_lo) && $past(dead) != '0) |-> !pwm_hi); // R6

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          is_slave,
  input  logic          ext_sync_i,
  input  logic          src_inv,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_hi,
  output logic          pwm_lo,
  output logic          reload_o
);

  // compare window: high from the rise match up to the fall match
  function automatic logic in_window(input logic signed [CW-1:0] c,
                                     input logic signed [CW-1:0] r,
                                     input logic signed [CW-1:0] f);
    return (c >= r) && (c < f);
  endfunction

  logic [CW-2:0]        act_mod;
  logic [CW-2:0]        mod_next;
  logic signed [CW-1:0] act_rise;
  logic signed [CW-1:0] act_fall;
  logic [DTW-1:0]       act_dead;
  logic                 xfer;
  logic signed [CW-1:0] cnt;
  logic                 rld;
  logic                 started;
  logic                 raw_src;
  logic                 pair_src;

  cpwm_regs #(.CW(CW), .DTW(DTW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rld      (rld),
    .act_mod  (act_mod),
    .mod_next (mod_next),
    .act_rise (act_rise),
    .act_fall (act_fall),
    .act_dead (act_dead),
    .xfer     (xfer)
  );

  cpwm_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .is_slave   (is_slave),
    .ext_sync_i (ext_sync_i),
    .act_mod    (act_mod),
    .mod_next   (mod_next),
    .cnt        (cnt),
    .rld        (rld),
    .started    (started)
  );

  assign raw_src  = in_window(cnt, act_rise, act_fall);
  assign pair_src = raw_src ^ src_inv;
  assign reload_o = rld;

  cpwm_deadtime #(.DTW(DTW)) u_dt (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (!started),
    .src    (pair_src),
    .dead   (act_dead),
    .pwm_hi (pwm_hi),
    .pwm_lo (pwm_lo)
  );

  AST_EMPTY_WINDOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !src_inv && act_fall <= act_rise) |=> !pwm_hi); // R3

  AST_XFER_ONLY_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> reload_o); // R4

endmodule

// File: tb/cpwm_channel_tb.sv
module cpwm_channel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 16;
  localparam int DTW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          m_hi, m_lo, m_reload;
  logic          s_hi, s_lo, s_reload;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  int m_p, m_hic, m_loc, m_ov, m_eq, s_hic, s_loc, sync_mis;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_channel #(.CW(CW), .DTW(DTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_slave(1'b0),
    .ext_sync_i(1'b0), .src_inv(1'b0), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(m_hi), .pwm_lo(m_lo), .reload_o(m_reload)
  );

  cpwm_channel #(.CW(CW), .DTW(DTW)) u_slave (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_slave(1'b1),
    .ext_sync_i(m_reload), .src_inv(1'b1), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(s_hi), .pwm_lo(s_lo), .reload_o(s_reload)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_reload();
    do @(negedge clk); while (!m_reload);
  endtask

  // counts one window from a reload cycle up to the next one
  task automatic measure();
    wait_reload();
    m_p = 0; m_hic = 0; m_loc = 0; m_ov = 0; m_eq = 0;
    s_hic = 0; s_loc = 0; sync_mis = 0;
    do begin
      m_p++;
      m_hic += int'(m_hi);
      m_loc += int'(m_lo);
      m_ov  += int'(m_hi && m_lo);
      m_eq  += int'(m_hi == m_lo);
      s_hic += int'(s_hi);
      s_loc += int'(s_lo);
      sync_mis += int'(s_reload != m_reload);
      @(negedge clk);
    end while (!m_reload);
  endtask

  task automatic settle_measure();
    measure();
    measure();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10 reset hi", int'(m_hi), 0);
    chk("R10 reset lo", int'(m_lo), 0);
    chk("R10 reset reload", int'(m_reload), 0);
  endtask

  task automatic t_basic();
    wr(3'd0, 10); wr(3'd1, -4); wr(3'd2, 4); wr(3'd3, 2); wr(3'd4, 0);
    @(negedge clk);
    enable = 1'b1;
    #1;
    chk("R10 first enabled cycle reloads", int'(m_reload), 1);
    chk("R10 outputs low before start", int'(m_hi | m_lo), 0);
    settle_measure();
    chk("R1 period", m_p, 21);
    chk("R2 hi count", m_hic, 6);
    chk("R6 lo count", m_loc, 11);
    chk("R6 overlap", m_ov, 0);
    chk("R9 slave sync", sync_mis, 0);
    chk("R8 inverted hi", s_hic, 11);
    chk("R8 inverted lo", s_loc, 6);
  endtask

  task automatic t_no_ldok();
    wr(3'd1, -2); wr(3'd2, 2);
    settle_measure();
    chk("R4 unarmed write ignored", m_hic, 6);
    wr(3'd4, 0);
    settle_measure();
    chk("R4 armed write applied", m_hic, 2);
  endtask

  task automatic t_empty();
    wr(3'd1, 3); wr(3'd2, -3); wr(3'd4, 0);
    settle_measure();
    chk("R3 hi never", m_hic, 0);
    chk("R3 lo always", m_loc, 21);
  endtask

  task automatic t_narrow();
    wr(3'd1, -1); wr(3'd2, 1); wr(3'd3, 3); wr(3'd4, 0);
    settle_measure();
    chk("R7 narrow pulse dropped", m_hic, 0);
    chk("R7 lo gap", m_loc, 16);
    chk("R6 overlap narrow", m_ov, 0);
  endtask

  task automatic t_dead_zero();
    wr(3'd1, -5); wr(3'd2, 5); wr(3'd3, 0); wr(3'd4, 0);
    settle_measure();
    chk("R6 dead0 hi", m_hic, 10);
    chk("R6 dead0 lo", m_loc, 11);
    chk("R6 dead0 complement", m_eq, 0);
  endtask

  task automatic t_collide();
    wr(3'd2, 7); wr(3'd4, 0);
    wait_reload();
    // same cycle as the transfer
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = CW'(-8);
    @(negedge clk);
    wr_en = 1'b0;
    settle_measure();
    chk("R5 late write not in transfer", m_hic, 12);
    wr(3'd4, 0);
    settle_measure();
    chk("R5 late write in next transfer", m_hic, 15);
  endtask

  task automatic t_mod_change();
    wr(3'd0, 6); wr(3'd1, -2); wr(3'd2, 2); wr(3'd3, 1); wr(3'd4, 0);
    settle_measure();
    chk("R1 new period", m_p, 13);
    chk("R2 new hi", m_hic, 3);
    chk("R6 new lo", m_loc, 8);
  endtask

  task automatic t_disable();
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 disabled hi", int'(m_hi), 0);
    chk("R10 disabled lo", int'(m_lo), 0);
    chk("R10 disabled reload", int'(m_reload), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_no_ldok();
    t_empty();
    t_narrow();
    t_dead_zero();
    t_collide();
    t_mod_change();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule